// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor's load/store port and one word-wide main-memory port. Each line holds a block of four 32-bit words, selected by the index field of the request address. A read that finds its line valid and its tag equal is answered in the same cycle. A read that misses raises a stall and fetches the whole aligned block from memory one word at a time. It then records the tag, marks the line valid and releases the stall, so the held request completes as a hit.

Stores are write-through with write-allocate. A store that hits updates its word in the line and places the address and data in a small posted write buffer, which drains toward memory while the processor continues. A store that misses first brings in the whole block, then completes as a store hit, so no word from a previous tag stays in the line. Before any block fill starts, the write buffer is fully drained, so a fill never reads memory ahead of an older pending write. The requester must hold its request steady while the stall is high.

Top module: `wt_dcache`

## Requirements
- R1: The address splits into byte offset bits 1:0 (ignored for reads), word-in-block bits 3:2, index bits IDX_W+3:4 and tag bits 31:IDX_W+4. With the defaults (IDX_W=4) the index is bits 7:4 and the tag is bits 31:8.
- R2: After reset every line is invalid, so the first access to any line stalls and fetches from memory, and no memory request is made while idle.
- R3: A read whose line is valid with a matching tag completes in the cycle it is presented: `cpu_stall` is low and `cpu_rdata` holds the word.
- R4: A read miss holds `cpu_stall` high and issues four memory reads (`mem_we`=0) of the aligned block, words 0, 1, 2, 3 in that order, each at address {tag, index, word, 2'b00}.
- R5: After a fill, every word of that block reads as a hit with the memory contents and no further memory traffic.
- R6: A store hit completes without a stall, updates the cached word, and later produces one memory write (`mem_we`=1) with the store's address (bits 31:2) and data.
- R7: A store miss first fills the whole block from memory and then merges the stored word. Afterwards the other three words read back their memory values and the stored word reads back the new data, followed by one memory write of that store.
- R8: The write buffer holds up to WB_DEPTH stores; a store presented while it is full stalls until an entry drains.
- R9: No fill read is sent to memory while any buffered store is pending; buffered writes reach memory before the fill's first read.
- R10: Buffered stores reach memory in the order the processor issued them.
- R11: A miss to a block with the same index but another tag replaces the line, so a later access to the earlier tag misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | High while the request cannot complete |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address; bits 1:0 are don't-care |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current memory request |

## Verification
A cold read shows the fill order and the miss stall. Reads of the neighbouring words and a byte-offset variant then separate a valid line from a refetch. A store hit and a store miss to a fresh index tell write-through apart from write-allocate: the miss must show four reads before its write, and the untouched words must keep their memory values. A burst of back-to-back stores against slow memory fills the buffer and exposes the full stall and the drain order. A store followed by a miss shows that the drain comes before the fill, and an address differing only in its tag shows eviction.

// File: rtl/dmc_pkg.sv
// Shared types for the write-through data cache.
package dmc_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DRAIN = 2'd1,
        FS_FILL  = 2'd2
    } fill_state_t;

    localparam int WORDS_PER_LINE = 4;
    localparam int WORD_SEL_W     = 2;
endpackage

// File: rtl/dmc_wbuf.sv
// Posted store queue toward memory.
// Holds {address, data} pairs in issue order. Assumes push is only
// requested when not full and pop only when not empty.
module dmc_wbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    // Store an entry at the tail on push.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/dmc_array.sv
// Tag, valid and data storage of the direct-mapped cache.
// One read port (combinational), one word write port, a line invalidate
// and a line validate-with-tag. Valid bits clear on reset; data and tags
// are not reset.
module dmc_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       rd_word,
    output logic             line_valid,
    output logic [TAG_W-1:0] line_tag,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [1:0]       wr_word,
    input  logic [31:0]      wr_data,
    input  logic             inval,
    input  logic             set_valid,
    input  logic [TAG_W-1:0] set_tag
);
    import dmc_pkg::*;
    localparam int LINES = 1 << IDX_W;

    logic [31:0]      data_q [LINES][WORDS_PER_LINE];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [LINES-1:0] valid_q;

    assign line_valid = valid_q[idx];
    assign line_tag   = tag_q[idx];
    assign rd_data    = data_q[idx][rd_word];

    // Word writes from fills and store hits.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[idx][wr_word] <= wr_data;
    end

    // Tag capture when a fill completes.
    always_ff @(posedge clk) begin
        if (set_valid) tag_q[idx] <= set_tag;
    end

    // Valid bits: cleared by reset and at fill start, set at fill end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inval) begin
            valid_q[idx] <= 1'b0;
        end else if (set_valid) begin
            valid_q[idx] <= 1'b1;
        end
    end

    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/dmc_fill.sv
// Miss sequencer: waits for the write buffer to empty, then reads the
// four words of the block in order. Assumes the requester holds the
// missing address steady while busy.
module dmc_fill (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wb_empty,
    input  logic       mem_ack,
    output logic       busy,
    output logic       fill_req,
    output logic [1:0] word_cnt,
    output logic       word_we,
    output logic       done
);
    import dmc_pkg::*;

    fill_state_t state;

    assign busy     = (state != FS_IDLE);
    assign fill_req = (state == FS_FILL);
    assign word_we  = fill_req && mem_ack;
    assign done     = word_we && (word_cnt == 2'd3);

    // Sequence drain, then four word reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            word_cnt <= '0;
        end else begin
            case (state)
                FS_IDLE:  if (start) state <= FS_DRAIN;
                FS_DRAIN: if (wb_empty) begin
                    state    <= FS_FILL;
                    word_cnt <= '0;
                end
                FS_FILL:  if (mem_ack) begin
                    word_cnt <= word_cnt + 1'b1;
                    if (word_cnt == 2'd3) state <= FS_IDLE;
                end
                default:  state <= FS_IDLE;
            endcase
        end
    end

    assert_fill_word_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && mem_ack && word_cnt != 2'd3) |=>
            (fill_req && word_cnt == $past(word_cnt) + 2'd1));
endmodule

// File: rtl/wt_dcache.sv
// Direct-mapped, write-through, write-allocate data cache with a posted
// write buffer. Assumes the processor holds cpu_req/addr/data steady while
// cpu_stall is high, and that memory holds one request at a time, ending it
// with a one-cycle mem_ack.
module wt_dcache #(
    parameter int IDX_W    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    localparam int OFF_W = 4;
    localparam int TAG_W = 32 - IDX_W - OFF_W;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [1:0]       req_word;
    logic             line_valid, hit;
    logic [TAG_W-1:0] line_tag;
    logic             busy, fill_req, fill_we, fill_done, fill_start;
    logic [1:0]       fill_cnt;
    logic             wb_push, wb_pop, wb_empty, wb_full;
    logic [31:0]      wb_addr, wb_data;
    logic             arr_we;
    logic [1:0]       arr_word;
    logic [31:0]      arr_wdata;

    assign req_tag  = cpu_addr[31 -: TAG_W];
    assign req_idx  = cpu_addr[OFF_W +: IDX_W];
    assign req_word = cpu_addr[3:2];
    assign hit      = line_valid && (line_tag == req_tag);

    // Processor side: start fills on a miss, push stores on a hit.
    assign fill_start = cpu_req && !hit && !busy;
    assign wb_push    = cpu_req && cpu_we && hit && !busy && !wb_full;
    assign cpu_stall  = cpu_req && (busy || !hit || (cpu_we && wb_full));

    // Array write port: fill words or the merged store word.
    assign arr_we    = fill_we || wb_push;
    assign arr_word  = fill_we ? fill_cnt : req_word;
    assign arr_wdata = fill_we ? mem_rdata : cpu_wdata;

    // Memory side: fill reads take the port only once the buffer is empty.
    assign mem_req   = fill_req || !wb_empty;
    assign mem_we    = !fill_req;
    assign mem_addr  = fill_req ? {req_tag, req_idx, fill_cnt, 2'b00} : wb_addr;
    assign mem_wdata = wb_data;
    assign wb_pop    = mem_ack && !fill_req && !wb_empty;

    dmc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .rd_word   (req_word),
        .line_valid(line_valid),
        .line_tag  (line_tag),
        .rd_data   (cpu_rdata),
        .wr_en     (arr_we),
        .wr_word   (arr_word),
        .wr_data   (arr_wdata),
        .inval     (fill_start),
        .set_valid (fill_done),
        .set_tag   (req_tag)
    );

    dmc_fill u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fill_start),
        .wb_empty (wb_empty),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .fill_req (fill_req),
        .word_cnt (fill_cnt),
        .word_we  (fill_we),
        .done     (fill_done)
    );

    dmc_wbuf #(.DEPTH(WB_DEPTH), .AW(32), .DW(32)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wb_push),
        .push_addr(cpu_addr),
        .push_data(cpu_wdata),
        .pop      (wb_pop),
        .head_addr(wb_addr),
        .head_data(wb_data),
        .empty    (wb_empty),
        .full     (wb_full)
    );

    assert_fill_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_empty);
    assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !line_valid) |-> cpu_stall);
    assert_full_store_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_full) |-> cpu_stall);
    assert_mem_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr[31:2])));
endmodule

// File: tb/test_wt_dcache.sv
// Directed bench for wt_dcache with a word-addressed memory responder.
module test_wt_dcache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    wt_dcache i_wt_dcache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: 256 words, programmable latency, transaction log.
    logic [31:0] memw [256];
    bit          log_we   [1024];
    logic [31:0] log_addr [1024];
    logic [31:0] log_data [1024];
    int          log_n = 0;
    int          mem_lat = 2;
    int          lat_cnt = 0;

    initial for (int i = 0; i < 256; i++) memw[i] = 32'hA500_0000 + i * 7;

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                log_we[log_n]   <= mem_we;
                log_addr[log_n] <= {mem_addr[31:2], 2'b00};
                log_data[log_n] <= mem_we ? mem_wdata : memw[mem_addr[9:2]];
                log_n <= log_n + 1;
                if (mem_we) memw[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= memw[mem_addr[9:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor access; returns the data and the number of stalled cycles.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_log(input int target);
        for (int i = 0; i < 2000 && log_n < target; i++) @(negedge clk);
    endtask

    localparam logic [31:0] BLK_A = 32'h0000_0040;  // index 4, tag 0
    localparam logic [31:0] BLK_B = 32'h0000_0080;  // index 8, tag 0
    localparam logic [31:0] BLK_C = 32'h0000_0140;  // index 4, tag 1
    localparam logic [31:0] BLK_D = 32'h0000_00C0;  // index 12, tag 0

    task automatic t_reset;
        check(mem_req == 1'b0, "R2 idle after reset no mem_req", {31'b0, mem_req}, 32'h0);
        check(cpu_stall == 1'b0, "R2 no stall without request", {31'b0, cpu_stall}, 32'h0);
    endtask

    task automatic t_cold_read;
        logic [31:0] rd; int st; int base;
        base = log_n;
        access(1'b0, BLK_A + 8, '0, rd, st);
        check(st > 0, "R2 first access misses", st, 1);
        check(rd == memw[(BLK_A + 8) >> 2], "R4 miss returns memory word", rd, memw[(BLK_A + 8) >> 2]);
        check(log_n - base == 4, "R4 four fill reads", log_n - base, 4);
        for (int k = 0; k < 4; k++)
            check(!log_we[base + k] && log_addr[base + k] == BLK_A + 4 * k,
                  "R4 fill read order", log_addr[base + k], BLK_A + 4 * k);
    endtask

    task automatic t_hits;
        logic [31:0] rd; int st; int base;
        base = log_n;
        for (int k = 0; k < 4; k++) begin
            access(1'b0, BLK_A + 4 * k, '0, rd, st);
            check(st == 0, "R3 read hit no stall", st, 0);
            check(rd == memw[(BLK_A >> 2) + k], "R5 hit data from fill", rd, memw[(BLK_A >> 2) + k]);
        end
        access(1'b0, BLK_A + 4 + 3, '0, rd, st);
        check(st == 0 && rd == memw[(BLK_A >> 2) + 1], "R1 byte offset ignored", rd, memw[(BLK_A >> 2) + 1]);
        check(log_n == base, "R5 hits make no memory traffic", log_n - base, 0);
    endtask

    task automatic t_store_hit;
        logic [31:0] rd; int st; int base;
        base = log_n;
        access(1'b1, BLK_A + 12, 32'h1234_5678, rd, st);
        check(st == 0, "R6 store hit no stall", st, 0);
        access(1'b0, BLK_A + 12, '0, rd, st);
        check(st == 0 && rd == 32'h1234_5678, "R6 cached word updated", rd, 32'h1234_5678);
        wait_log(base + 1);
        check(log_n - base == 1 && log_we[base], "R6 one memory write", log_n - base, 1);
        check(log_addr[base] == BLK_A + 12 && log_data[base] == 32'h1234_5678,
              "R6 write address and data", log_data[base], 32'h1234_5678);
    endtask

    task automatic t_store_miss;
        logic [31:0] rd; int st; int base;
        base = log_n;
        access(1'b1, BLK_B + 4, 32'hCAFE_0001, rd, st);
        check(st > 0, "R7 store miss stalls", st, 1);
        wait_log(base + 5);
        for (int k = 0; k < 4; k++)
            check(!log_we[base + k] && log_addr[base + k] == BLK_B + 4 * k,
                  "R7 block filled before store", log_addr[base + k], BLK_B + 4 * k);
        check(log_we[base + 4] && log_data[base + 4] == 32'hCAFE_0001,
              "R7 store written through after fill", log_data[base + 4], 32'hCAFE_0001);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] exp;
            exp = (k == 1) ? 32'hCAFE_0001 : memw[(BLK_B >> 2) + k];
            access(1'b0, BLK_B + 4 * k, '0, rd, st);
            check(st == 0 && rd == exp, "R7 merged line contents", rd, exp);
        end
    endtask

    task automatic t_buffer_full;
        logic [31:0] rd; int st; int base; int stalls [5];
        mem_lat = 20;
        base = log_n;
        for (int k = 0; k < 5; k++) begin
            access(1'b1, BLK_A + 4 * (k % 4), 32'hB000_0000 + k, rd, st);
            stalls[k] = st;
        end
        for (int k = 0; k < 4; k++)
            check(stalls[k] == 0, "R8 stores accepted while not full", stalls[k], 0);
        check(stalls[4] > 0, "R8 store stalls when buffer full", stalls[4], 1);
        wait_log(base + 5);
        for (int k = 0; k < 5; k++)
            check(log_we[base + k] && log_data[base + k] == 32'hB000_0000 + k &&
                  log_addr[base + k] == BLK_A + 4 * (k % 4),
                  "R10 writes drain in order", log_data[base + k], 32'hB000_0000 + k);
        access(1'b0, BLK_A, '0, rd, st);
        check(rd == 32'hB000_0004, "R10 last store wins in cache", rd, 32'hB000_0004);
    endtask

    task automatic t_drain_first;
        logic [31:0] rd; int st; int base;
        mem_lat = 10;
        base = log_n;
        access(1'b1, BLK_A + 4, 32'hD00D_0001, rd, st);
        access(1'b0, BLK_D, '0, rd, st);
        check(st > 0, "R9 miss after store stalls", st, 1);
        check(log_we[base] && log_data[base] == 32'hD00D_0001,
              "R9 buffered write before fill", log_data[base], 32'hD00D_0001);
        check(log_n - base == 5 && !log_we[base + 1] && log_addr[base + 1] == BLK_D,
              "R9 fill follows drain", log_addr[base + 1], BLK_D);
        mem_lat = 2;
    endtask

    task automatic t_conflict;
        logic [31:0] rd; int st;
        access(1'b0, BLK_C, '0, rd, st);
        check(st > 0 && rd == memw[BLK_C >> 2], "R11 other tag misses", rd, memw[BLK_C >> 2]);
        access(1'b0, BLK_C + 4, '0, rd, st);
        check(st == 0, "R11 new tag now hits", st, 0);
        access(1'b0, BLK_A + 8, '0, rd, st);
        check(st > 0 && rd == memw[(BLK_A >> 2) + 2], "R11 evicted tag misses again", rd,
              memw[(BLK_A >> 2) + 2]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_cold_read();
        t_hits();
        t_store_hit();
        t_store_miss();
        t_buffer_full();
        t_drain_first();
        t_conflict();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule